// File: doc/BRIEF.md
# Z80 I/O Wait-State Bridge

This block connects the I/O side of a Z80-style processor bus to a slower service engine. A qualified I/O read or write pulls the CPU's wait line low in the same cycle, with no decision from the engine needed. The bridge then captures the direction, the register select bit and any write byte, and raises a request toward the engine. The CPU stays stalled for as long as the engine takes. When the engine is done, it pulses a clear line and, for a read, supplies the byte to return. The CPU then finishes its cycle with that byte on the bus.

Interrupt-acknowledge cycles, where M1 is low together with IORQ, pass through untouched. Each bus cycle gives exactly one request. A new request cannot start until IORQ has gone high again.

Top module: `z80_io_wait_bridge`

## Requirements
- R1: When iorq_n is low, m1_n is high and either rd_n or wr_n is low, wait_n goes low in the same cycle, before any clock edge, whenever no request is pending and the current bus cycle has not already been served.
- R2: wait_n stays low until svc_clr is sampled high at a rising edge while svc_req is high. After that edge, wait_n and svc_req are both high and low respectively.
- R3: On a write cycle (wr_n low), svc_write is 1 one edge after the cycle is qualified. svc_wdata holds the bus byte seen at that edge, and it stays fixed while the request is pending even if the bus changes.
- R4: On a read cycle (rd_n low, wr_n high), svc_write is 0 and svc_wdata is 0.
- R5: svc_sel equals the a0 value at the qualifying edge: 0 selects the data register, 1 selects the control register.
- R6: With m1_n low, an I/O cycle never pulls wait_n low and never raises svc_req.
- R7: bus_oe is 1 exactly when iorq_n, rd_n and m1_n are low and high as for a read (iorq_n=0, rd_n=0, m1_n=1). After a read is cleared, bus_dout equals the svc_rdata value sampled with svc_clr.
- R8: After a clear, wait_n stays high and no new request is raised for as long as iorq_n remains low.
- R9: Synchronous reset (rst high at a rising edge) clears svc_req, svc_write, svc_sel, svc_wdata and bus_dout to 0 and releases wait_n.
- R10: svc_clr pulsed while no request is pending has no effect on any output.
- R11: The stall lasts for any number of cycles the engine chooses. There is no internal time limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| m1_n | input | 1 | CPU opcode-fetch / acknowledge marker, active low |
| a0 | input | 1 | Register select from the CPU address |
| bus_din | input | BUS_W | Data bus as driven by the CPU |
| bus_dout | output | BUS_W | Byte returned to the CPU on reads |
| bus_oe | output | 1 | Enable for driving bus_dout onto the bus |
| wait_n | output | 1 | Wait line to the CPU, active low |
| svc_req | output | 1 | Pending request toward the engine |
| svc_write | output | 1 | Request is a write (1) or read (0) |
| svc_sel | output | 1 | Captured register select |
| svc_wdata | output | BUS_W | Captured write byte |
| svc_clr | input | 1 | Engine finished; releases the stall |
| svc_rdata | input | BUS_W | Read byte supplied with svc_clr |

## Verification
Several internal faults show up at the ports within a cycle or two:

- A stuck or missing stall flag shows up in the cycle a qualified strobe appears. Either wait_n fails to fall at once, or it stays low after the clear edge.
- A wrong served flag shows up while IORQ is still low after a clear, as a second wait or request.
- Bad capture shows up as svc_wdata following the live bus, or as a wrong select or direction one edge after qualification.

Sweeping stall lengths from zero upward shows that no hidden counter ends the stall.

// File: rtl/iobr_pkg.sv
package iobr_pkg;
    parameter int BUS_W = 8;

    typedef struct packed {
        logic             stall;
        logic             served;
        logic             wr;
        logic             sel;
        logic [BUS_W-1:0] wdata;
        logic [BUS_W-1:0] rdata;
    } iobr_state_t;
endpackage

// File: rtl/iobr_decode.sv
module iobr_decode (
    input  logic rst,
    input  logic iorq_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic m1_n,
    input  logic stall,
    input  logic served,
    output logic start,
    output logic is_write,
    output logic drive
);
    logic io_active;
    logic strobe;

    always_comb begin
        io_active = !iorq_n && m1_n;
        strobe    = !rd_n || !wr_n;
        start     = !rst && io_active && strobe && !stall && !served;
        is_write  = !wr_n;
        drive     = io_active && !rd_n;
    end
endmodule

// File: rtl/iobr_state.sv
module iobr_state
    import iobr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iorq_n,
    input  logic             start,
    input  logic             is_write,
    input  logic             a0,
    input  logic [BUS_W-1:0] bus_din,
    input  logic             clr,
    input  logic [BUS_W-1:0] clr_rdata,
    output iobr_state_t      st_q
);
    iobr_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.stall = 1'b1;
            st_d.wr    = is_write;
            st_d.sel   = a0;
            st_d.wdata = is_write ? bus_din : '0;
        end else if (st_q.stall && clr) begin
            st_d.stall  = 1'b0;
            st_d.served = 1'b1;
            if (!st_q.wr) begin
                st_d.rdata = clr_rdata;
            end
        end else if (iorq_n) begin
            st_d.served = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/z80_io_wait_bridge.sv
module z80_io_wait_bridge
    import iobr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iorq_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             m1_n,
    input  logic             a0,
    input  logic [BUS_W-1:0] bus_din,
    output logic [BUS_W-1:0] bus_dout,
    output logic             bus_oe,
    output logic             wait_n,
    output logic             svc_req,
    output logic             svc_write,
    output logic             svc_sel,
    output logic [BUS_W-1:0] svc_wdata,
    input  logic             svc_clr,
    input  logic [BUS_W-1:0] svc_rdata
);
    iobr_state_t st_q;
    logic        start;
    logic        is_write;
    logic        drive;

    iobr_decode u_dec (
        .rst      (rst),
        .iorq_n   (iorq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .m1_n     (m1_n),
        .stall    (st_q.stall),
        .served   (st_q.served),
        .start    (start),
        .is_write (is_write),
        .drive    (drive)
    );

    iobr_state u_st (
        .clk       (clk),
        .rst       (rst),
        .iorq_n    (iorq_n),
        .start     (start),
        .is_write  (is_write),
        .a0        (a0),
        .bus_din   (bus_din),
        .clr       (svc_clr),
        .clr_rdata (svc_rdata),
        .st_q      (st_q)
    );

    always_comb begin
        wait_n    = !(st_q.stall || start);
        svc_req   = st_q.stall;
        svc_write = st_q.wr;
        svc_sel   = st_q.sel;
        svc_wdata = st_q.wdata;
        bus_dout  = st_q.rdata;
        bus_oe    = drive;
    end
endmodule

// File: rtl/iobr_chk.sv
module iobr_chk
    import iobr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             iorq_n,
    input logic             rd_n,
    input logic             m1_n,
    input logic             bus_oe,
    input logic             wait_n,
    input logic             svc_req,
    input logic             svc_write,
    input logic             svc_sel,
    input logic [BUS_W-1:0] svc_wdata,
    input logic             svc_clr
);
    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> !wait_n); // R2

    AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (svc_req && svc_clr) |=> !svc_req); // R2

    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (svc_req && !svc_clr) |=> (svc_req && $stable(svc_wdata) && $stable(svc_sel) && $stable(svc_write))); // R3

    AST_IACK_PASS: assert property (@(posedge clk) disable iff (rst)
        (!iorq_n && !m1_n && !svc_req) |-> wait_n); // R6

    AST_OE_GATED: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!iorq_n && !rd_n && m1_n)); // R7

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (svc_req && svc_clr && !iorq_n) |=> (wait_n && !svc_req)); // R8
endmodule

bind z80_io_wait_bridge iobr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .m1_n      (m1_n),
    .bus_oe    (bus_oe),
    .wait_n    (wait_n),
    .svc_req   (svc_req),
    .svc_write (svc_write),
    .svc_sel   (svc_sel),
    .svc_wdata (svc_wdata),
    .svc_clr   (svc_clr)
);

// File: tb/sim_z80_io_wait_bridge.sv
module sim_z80_io_wait_bridge;
    localparam int CLK_P = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         iorq_n, rd_n, wr_n, m1_n, a0;
    logic [W-1:0] bus_din, bus_dout, svc_wdata, svc_rdata;
    logic         bus_oe, wait_n, svc_req, svc_write, svc_sel, svc_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    z80_io_wait_bridge u0 (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .m1_n(m1_n), .a0(a0), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .wait_n(wait_n), .svc_req(svc_req),
        .svc_write(svc_write), .svc_sel(svc_sel), .svc_wdata(svc_wdata),
        .svc_clr(svc_clr), .svc_rdata(svc_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; a0 = 0;
        bus_din = '0; svc_clr = 0; svc_rdata = '0;
    endtask

    // one I/O cycle; waits = cycles the engine holds off before clearing
    task automatic io_cycle(input bit wr, input bit sel, input logic [W-1:0] wd,
                            input logic [W-1:0] rb, input int waits);
        @(negedge clk);
        iorq_n = 0; a0 = sel; bus_din = wd;
        rd_n = wr; wr_n = !wr;
        #1;
        chk("R1 wait_n immediate", int'(wait_n), 0);
        chk("R7 bus_oe on strobe", int'(bus_oe), int'(!wr));
        @(negedge clk);
        chk("R2 req raised", int'(svc_req), 1);
        chk("R3/R4 direction", int'(svc_write), int'(wr));
        chk("R5 select", int'(svc_sel), int'(sel));
        chk("R3/R4 wdata", int'(svc_wdata), wr ? int'(wd) : 0);
        bus_din = ~wd;
        a0 = !sel;
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            chk("R11 wait held", int'(wait_n), 0);
            chk("R3 wdata held", int'(svc_wdata), wr ? int'(wd) : 0);
            chk("R5 sel held", int'(svc_sel), int'(sel));
        end
        svc_clr = 1; svc_rdata = rb;
        @(negedge clk);
        svc_clr = 0; svc_rdata = 8'h5a;
        #1;
        chk("R2 wait released", int'(wait_n), 1);
        chk("R2 req dropped", int'(svc_req), 0);
        if (!wr) begin
            chk("R7 read byte", int'(bus_dout), int'(rb));
            chk("R7 oe during read", int'(bus_oe), 1);
        end
        @(negedge clk);
        chk("R8 no second wait", int'(wait_n), 1);
        chk("R8 no second req", int'(svc_req), 0);
        iorq_n = 1; rd_n = 1; wr_n = 1;
        #1;
        chk("R7 oe off", int'(bus_oe), 0);
    endtask

    initial begin
        bus_idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R9 reset req", int'(svc_req), 0);
        chk("R9 reset wait", int'(wait_n), 1);
        chk("R9 reset wdata", int'(svc_wdata), 0);
        chk("R9 reset dout", int'(bus_dout), 0);

        // sweep direction, select and stall length
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 2; s++)
                for (int n = 0; n < 7; n++) begin
                    logic [W-1:0] wd;
                    wd = W'(s*37 + d*91 + n*13 + 5);
                    io_cycle(d[0], s[0], wd, ~wd, n);
                end
        io_cycle(1'b1, 1'b1, 8'hff, 8'h00, 40);
        io_cycle(1'b0, 1'b0, 8'h00, 8'h80, 25);

        // interrupt acknowledge: M1 low with IORQ
        @(negedge clk);
        m1_n = 0; iorq_n = 0; rd_n = 0;
        #1;
        chk("R6 iack no wait", int'(wait_n), 1);
        chk("R7 iack no oe", int'(bus_oe), 0);
        repeat (3) @(negedge clk);
        chk("R6 iack no req", int'(svc_req), 0);
        bus_idle();

        // clear while idle
        @(negedge clk);
        svc_clr = 1; svc_rdata = 8'h77;
        @(negedge clk);
        svc_clr = 0;
        chk("R10 idle clr req", int'(svc_req), 0);
        chk("R10 idle clr dout", int'(bus_dout), 8'h80);
        chk("R10 idle clr wait", int'(wait_n), 1);

        // reset mid-stall
        @(negedge clk);
        iorq_n = 0; wr_n = 0; a0 = 1; bus_din = 8'hc3;
        @(negedge clk);
        chk("R3 req before reset", int'(svc_req), 1);
        rst = 1;
        @(negedge clk);
        bus_idle();
        @(negedge clk);
        rst = 0;
        chk("R9 mid reset req", int'(svc_req), 0);
        chk("R9 mid reset sel", int'(svc_sel), 0);
        chk("R9 mid reset wdata", int'(svc_wdata), 0);
        chk("R9 mid reset write", int'(svc_write), 0);
        chk("R9 mid reset dout", int'(bus_dout), 0);
        chk("R9 mid reset wait", int'(wait_n), 1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule